// File: doc/BRIEF.md
# Pixel-Group Token Readout Arbiter

This block gathers hit words from a cluster of eight pixels arranged two wide by four tall. Several such clusters stack along a double column, 64 per column. A pixel that has recorded a hit raises its request line and presents a 31-bit word, which carries its own pixel index. The block hands a token from pixel to pixel in round-robin order and serves one pending pixel per cycle. It acknowledges that pixel and moves the word into a two-entry FIFO. Pixels without hits are never visited, so the readout is data-driven and zero-suppressed.

Each word leaves toward the end-of-column logic as a 37-bit column word. The upper six bits hold the cluster index from `grp_addr`, and the lower 31 bits hold the pixel word unchanged. The output is a valid/ready stream with these back-pressure rules:

- While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- A word is consumed on a clock edge where both `out_valid` and `out_ready` are high.
- When the FIFO is full and nothing is consumed, no pixel is acknowledged. Pending pixels keep their request raised until space frees up.

Top module: `pixgrp_readout`

## Requirements
- R1: During and right after reset, `out_valid` is low and `pix_ack` is all zero.
- R2: `pix_ack` has at most one bit set in any cycle. A bit is set only for a pixel whose request was high at the clock edge that produced it, and it stays high for exactly one cycle.
- R3: Pending pixels are served in cyclic order, starting at the pixel after the last one served. After reset the search starts at pixel 0. Pixel i is bit i of `pix_req`, `pix_ack` and the i-th 31-bit slice of `pix_data`.
- R4: With the FIFO holding two words and `out_ready` low, no acknowledge is issued. A request that was held back is served later, and its word is not lost.
- R5: Each output word is `{grp_addr[5:0], pixel_word[30:0]}`. Words come out in the order the pixels were acknowledged.
- R6: If `out_valid` is high and `out_ready` is low at a clock edge, then after that edge `out_valid` is still high and `out_data` is unchanged.
- R7: When the FIFO is full and a word is consumed at an edge, a pending pixel is acknowledged at that same edge.
- R8: Only pixels that request produce words. When no request is pending and the FIFO is empty, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_req | input | 8 | Per-pixel request, held until acknowledged |
| pix_data | input | 248 | Eight 31-bit pixel words; pixel i at bits [31*i+30:31*i] |
| pix_ack | output | 8 | One-cycle acknowledge; the word was taken at the edge that raised it |
| grp_addr | input | 6 | Index of this cluster within the column |
| out_valid | output | 1 | Column word available |
| out_ready | input | 1 | Column side accepts the word |
| out_data | output | 37 | Cluster index over pixel word |

## Verification
The assertions assume four things about the inputs:

- A pixel keeps its request and word steady until it sees its acknowledge.
- A pixel drops its request in the cycle after the acknowledge, unless it presents a new word.
- `grp_addr` does not change while words are queued.
- The stall-hold property relies on that constant cluster index.

The stimulus meets these conditions by driving inputs only on falling edges. It clears a pixel's request on the first falling edge after its acknowledge. It changes the cluster index only after the FIFO has drained and two idle cycles have passed.

// File: rtl/pixgrp_pkg.sv
package pixgrp_pkg;
  // Default geometry of one pixel cluster
  localparam int GRP_PIX   = 8;
  localparam int PIX_WORD  = 31;
  localparam int GRP_IDX_W = 6;
  localparam int FIFO_DEP  = 2;

  // (base + step) reduced into 0..n-1, for step in 1..n
  function automatic int wrap_add(input int base, input int step, input int n);
    int s;
    s = base + step;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/pixgrp_token_arb.sv
module pixgrp_token_arb
  import pixgrp_pkg::*;
#(
  parameter int N = GRP_PIX,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          allow,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_fire
);
  // Token: index of the pixel served most recently
  logic [IW-1:0] tok;
  logic          found;
  logic [IW-1:0] pick;
  logic [IW-1:0] posi;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    posi  = '0;
    for (int k = 1; k <= N; k++) begin
      posi = IW'(wrap_add(int'(tok), k, N));
      if (!found && req[posi]) begin
        found = 1'b1;
        pick  = posi;
      end
    end
  end

  assign gnt_fire = found && allow;
  assign gnt_idx  = pick;

  generate
    for (genvar i = 0; i < N; i++) begin : g_gnt
      assign gnt[i] = gnt_fire && (pick == IW'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        tok <= IW'(N - 1);
    else if (gnt_fire) tok <= pick;
  end
endmodule

// File: rtl/pixgrp_sel.sv
module pixgrp_sel #(
  parameter int N  = 8,
  parameter int W  = 31,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] words,
  input  logic [IW-1:0]  idx,
  output logic [W-1:0]   word
);
  // AND-OR selection of the granted pixel's word
  always_comb begin
    word = '0;
    for (int i = 0; i < N; i++) begin
      if (idx == IW'(i)) word = word | words[i*W +: W];
    end
  end
endmodule

// File: rtl/pixgrp_fifo.sv
module pixgrp_fifo #(
  parameter int W     = 31,
  parameter int DEPTH = 2,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_rd;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({wr_en, do_rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/pixgrp_readout.sv
module pixgrp_readout
  import pixgrp_pkg::*;
#(
  parameter int N     = GRP_PIX,
  parameter int W     = PIX_WORD,
  parameter int AW    = GRP_IDX_W,
  parameter int DEPTH = FIFO_DEP,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int OW = AW + W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pix_req,
  input  logic [N*W-1:0] pix_data,
  output logic [N-1:0]  pix_ack,
  input  logic [AW-1:0] grp_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data
);
  logic [N-1:0]  ack_q;
  logic [N-1:0]  req_live;
  logic [N-1:0]  gnt;
  logic [IW-1:0] gnt_idx;
  logic          gnt_fire;
  logic [W-1:0]  sel_word;
  logic [W-1:0]  head;
  logic          f_empty, f_full;
  logic          pop, room;

  // A pixel acknowledged last edge is still dropping its request: skip it
  assign req_live = pix_req & ~ack_q;
  assign pop      = out_valid && out_ready;
  assign room     = !f_full || pop;

  pixgrp_token_arb #(.N(N)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_live), .allow(room),
    .gnt(gnt), .gnt_idx(gnt_idx), .gnt_fire(gnt_fire)
  );

  pixgrp_sel #(.N(N), .W(W)) u_sel (
    .words(pix_data), .idx(gnt_idx), .word(sel_word)
  );

  pixgrp_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(gnt_fire), .wr_data(sel_word),
    .rd_en(pop), .rd_data(head), .empty(f_empty), .full(f_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= gnt;
  end

  assign pix_ack   = ack_q;
  assign out_valid = !f_empty;
  assign out_data  = {grp_addr, head};
endmodule

// File: rtl/pixgrp_readout_chk.sv
module pixgrp_readout_chk #(
  parameter int N     = 8,
  parameter int OW    = 37,
  parameter int DEPTH = 2,
  localparam int MW = $clog2(DEPTH + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pix_req,
  input logic [N-1:0]  pix_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data
);
  // Occupancy model fed only by the port handshakes
  logic          pop_d;
  logic [MW-1:0] occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pop_d <= 1'b0;
      occ   <= '0;
    end else begin
      pop_d <= out_valid && out_ready;
      occ   <= occ + MW'(|pix_ack) - MW'(pop_d);
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_ack)); // R2
  AST_ACK_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|pix_ack) |-> ((pix_ack & $past(pix_req)) == pix_ack)); // R2
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_WRITE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|pix_ack) |-> out_valid); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && pix_ack == '0 && pix_req == '0) |=> !out_valid); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= MW'(DEPTH)); // R4
endmodule

bind pixgrp_readout pixgrp_readout_chk #(.N(N), .OW(OW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .pix_ack(pix_ack),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/pixgrp_readout_test.sv
module pixgrp_readout_test;
  localparam int N  = 8;
  localparam int W  = 31;
  localparam int AW = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   pix_req;
  logic [N*W-1:0] pix_data;
  logic [N-1:0]   pix_ack;
  logic [AW-1:0]  grp_addr;
  logic           out_valid;
  logic           out_ready;
  logic [AW+W-1:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pixgrp_readout uut (
    .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .pix_data(pix_data),
    .pix_ack(pix_ack), .grp_addr(grp_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pword(input int pat, input int trial, input int i);
    return {4'd0, 8'(pat), 16'(trial), 3'(i)};
  endfunction

  function automatic bit rdy_of(input int mode, input int c);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (c % 3) != 2;
    return c >= 6;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lastp;
    rst_n = 1'b0; pix_req = '0; pix_data = '0; out_ready = 1'b0; grp_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 0);
    check(pix_ack == '0, "R1 ack in reset", 64'(pix_ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && pix_ack == '0, "R1 after reset", 64'({out_valid, pix_ack}), 0);

    lastp = N - 1;
    for (int pat = 1; pat < 256; pat++) begin
      int order[N];
      int n, acks, outs, c, mode, idx;
      bit prev_stall;
      logic [AW+W-1:0] prev_data;
      mode = pat % 3;
      n = 0;
      for (int k = 1; k <= N; k++) begin
        int p;
        p = (lastp + k) % N;
        if (pat[p]) begin order[n] = p; n++; end
      end
      lastp = order[n-1];
      grp_addr = AW'(pat);
      for (int i = 0; i < N; i++) pix_data[i*W +: W] = pword(pat, pat, i);
      pix_req = N'(pat);
      out_ready = rdy_of(mode, 0);
      acks = 0; outs = 0; c = 0; prev_stall = 1'b0; prev_data = '0;
      while (outs < n && c < 80) begin
        @(negedge clk);
        c++;
        if (pix_ack != '0) begin
          check($countones(pix_ack) == 1, "R2 single ack", 64'(pix_ack), 1);
          check((pix_ack & pix_req) == pix_ack, "R2 ack to requester", 64'(pix_ack), 64'(pix_req));
          idx = 0;
          for (int i = 0; i < N; i++) if (pix_ack[i]) idx = i;
          if (acks < n)
            check(idx == order[acks], "R3 token order", 64'(idx), 64'(order[acks]));
          acks++;
          pix_req = pix_req & ~pix_ack;
        end
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R6 stall hold", 64'(out_data), 64'(prev_data));
        if (mode == 2 && c == 6)
          check(acks == ((n < 2) ? n : 2), "R4 full blocks ack", 64'(acks), 64'((n < 2) ? n : 2));
        if (mode == 2 && c == 7)
          check(acks == ((n < 3) ? n : 3), "R7 write on pop when full", 64'(acks), 64'((n < 3) ? n : 3));
        out_ready = rdy_of(mode, c);
        if (out_valid && out_ready) begin
          logic [AW+W-1:0] exp_w;
          exp_w = {AW'(pat), pword(pat, pat, (outs < n) ? order[outs] : 0)};
          check(out_data == exp_w, "R5 column word", 64'(out_data), 64'(exp_w));
          outs++;
        end
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
      end
      check(outs == n, "R4 all words delivered", 64'(outs), 64'(n));
      @(negedge clk);
      out_ready = 1'b0;
      check(pix_req == '0 && acks == n, "R8 ack count", 64'(acks), 64'(n));
      repeat (2) begin
        @(negedge clk);
        check(!out_valid && pix_ack == '0, "R8 idle quiet", 64'({out_valid, pix_ack}), 0);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule